// File: doc/BRIEF.md
# Clock-Compensated Beep Tone Generator

This block drives a single beeper line with a square wave. Inside it a free-running counter advances once every second clock. A multiplexer picks one counter bit, the tap, and passes it to the output while the block is enabled. Software chooses the pitch by setting a bit in a select field: a higher bit gives a lower tone.

Power management can slow the system clock to one half or one thirty-second of full speed. The block takes the current clock-ratio code as an input and moves the tap down by one or by five positions. The beeper's audible frequency therefore stays the same without any software action. If the moved index would fall below bit 0, it is held at bit 0.

Two registers are reached through a simple write port. Address 0 holds the enable and address 1 holds the tap-select field. Neither can be read back. The beep output is registered.

Top module: `tone_beep_gen`

## Requirements
- R1: While `rst_ni` is low, `beep_o` is low, and the counter, enable and select state are all clear. `rst_ni` is asserted asynchronously and released through two synchronizing flops, so the first clock edge with working logic is the third rising edge after `rst_ni` goes high.
- R2: The counter starts at zero and advances by one on every second active clock edge, beginning with the second active edge. It wraps modulo 2^(SEL_LSB+SEL_W). It keeps running whether or not the output is enabled.
- R3: With ratio code 2'b00 (full speed), or the spare code 2'b11 treated as full speed, and a non-empty select field whose lowest set bit is at field index i, `beep_o` after an edge equals counter bit SEL_LSB+i as it stood before that edge.
- R4: With ratio code 2'b01 (half speed), the tap is SEL_LSB+i-1. With ratio code 2'b10 (one thirty-second speed), the tap is SEL_LSB+i-5. Any negative tap index is clamped to bit 0.
- R5: A write to address 0 stores `wr_data_i[0]` as the enable. While the enable is clear, `beep_o` is low from the next edge on.
- R6: A write to address 1 stores `wr_data_i[SEL_LSB+SEL_W-1:SEL_LSB]` as the select field, which is bits 18:10 with the default parameters. When several bits are set, the lowest one decides the tap.
- R7: When the select field is all zero, `beep_o` is low.
- R8: Reserved write bits have no effect. These are bits 31:1 at address 0, and every bit outside the select field at address 1.
- R9: A change of ratio code moves the tap at the next edge. It neither restarts nor disturbs the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_addr_i | input | 1 | Register address: 0 enable, 1 tap select |
| wr_data_i | input | 32 | Write data |
| ratio_i | input | 2 | Current clock-ratio code: 00 full, 01 half, 10 one thirty-second, 11 treated as full |
| beep_o | output | 1 | Square-wave beeper output |

## Verification
The bench builds the block with SEL_LSB=2 and SEL_W=6, which gives an 8-bit counter with taps 2 to 7. With these values the counter wraps every 512 clocks, so several wraps fit into a short run and the counter-wrap behaviour can be checked. At one thirty-second speed, every field index below 3 yields a negative tap, so the clamp to bit 0 is exercised by ordinary stimulus. The output is compared on every cycle against a model built from the requirements. This model covers enable toggling, multi-bit and empty fields, reserved bits, and ratio codes that change in the middle of a tone.

// File: rtl/tone_pkg.sv
package tone_pkg;

  typedef enum logic [1:0] {
    RATIO_FULL  = 2'b00,
    RATIO_HALF  = 2'b01,
    RATIO_DIV32 = 2'b10,
    RATIO_SPARE = 2'b11
  } ratio_e;

  localparam logic ADDR_ENABLE = 1'b0;
  localparam logic ADDR_SELECT = 1'b1;

  localparam logic [2:0] SHIFT_HALF  = 3'd1;
  localparam logic [2:0] SHIFT_DIV32 = 3'd5;

  // number of tap positions to move down for a given clock-ratio code
  function automatic logic [2:0] ratio_shift(input logic [1:0] code);
    logic [2:0] sh;
    case (ratio_e'(code))
      RATIO_HALF:  sh = SHIFT_HALF;
      RATIO_DIV32: sh = SHIFT_DIV32;
      default:     sh = 3'd0;
    endcase
    return sh;
  endfunction

endpackage

// File: rtl/tone_rst_sync.sv
module tone_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/tone_counter.sv
module tone_counter #(
  parameter int unsigned CNT_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);

  logic             phase_q;
  logic             phase_d;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  // half-rate clock enable: counter steps on every other edge
  always_comb begin
    phase_d = ~phase_q;
    cnt_en  = phase_q;
    cnt_d   = cnt_q;
    if (cnt_en) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R2: the enable strobe alternates every edge
  a_r2_phase_alternates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q |=> !phase_q);

  // R2: counter only moves on the strobe, by exactly one
  a_r2_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  a_r2_hold_off_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_q |=> $stable(cnt_q));

endmodule

// File: rtl/tone_tap_select.sv
module tone_tap_select
  import tone_pkg::*;
#(
  parameter int unsigned SEL_LSB = 10,
  parameter int unsigned SEL_W   = 9,
  parameter int unsigned CNT_W   = SEL_LSB + SEL_W,
  parameter int unsigned TAP_W   = $clog2(CNT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [1:0]       ratio_i,
  output logic             valid_o,
  output logic [TAP_W-1:0] tap_o
);

  localparam int unsigned IDX_W = (SEL_W > 1) ? $clog2(SEL_W) : 1;
  localparam int unsigned EXT_W = TAP_W + 1;
  localparam int unsigned TOP_TAP = SEL_LSB + SEL_W - 1;

  logic [IDX_W-1:0] low_idx;
  logic             any_set;
  logic [EXT_W-1:0] base_w;
  logic [EXT_W-1:0] shift_w;
  logic [EXT_W-1:0] eff_w;

  // lowest-set-bit priority encoder (scan from the top, last hit wins)
  always_comb begin
    low_idx = '0;
    any_set = 1'b0;
    for (int i = SEL_W - 1; i >= 0; i--) begin
      if (sel_i[i]) begin
        low_idx = IDX_W'(i);
        any_set = 1'b1;
      end
    end
  end

  // ratio compensation with clamp at bit 0
  always_comb begin
    base_w  = EXT_W'(SEL_LSB) + EXT_W'(low_idx);
    shift_w = EXT_W'(ratio_shift(ratio_i));
    if (base_w >= shift_w) begin
      eff_w = base_w - shift_w;
    end else begin
      eff_w = '0;
    end
  end

  assign valid_o = any_set;
  assign tap_o   = eff_w[TAP_W-1:0];

  // R6: encoder picks a set bit with nothing set below it
  a_r6_lowest_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (sel_i[low_idx] &&
                 ((sel_i & ((SEL_W'(1) << low_idx) - SEL_W'(1))) == '0)));

  // R7: no valid tap only for an empty field
  a_r7_empty_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (sel_i == '0));

  // R4: compensation never moves the tap above the field's top bit
  a_r4_tap_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (32'(tap_o) <= TOP_TAP));

  // R3: at full speed the tap stays inside the select field
  a_r3_full_in_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (ratio_i == RATIO_FULL)) |-> (32'(tap_o) >= SEL_LSB));

endmodule

// File: rtl/tone_beep_gen.sv
module tone_beep_gen
  import tone_pkg::*;
#(
  parameter int unsigned SEL_LSB = 10,
  parameter int unsigned SEL_W   = 9
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        wr_addr_i,
  input  logic [31:0] wr_data_i,
  input  logic [1:0]  ratio_i,
  output logic        beep_o
);

  localparam int unsigned CNT_W = SEL_LSB + SEL_W;
  localparam int unsigned TAP_W = $clog2(CNT_W);

  logic             rst_sync_n;
  logic [CNT_W-1:0] cnt;
  logic             tap_valid;
  logic [TAP_W-1:0] tap;

  logic             en_q;
  logic             en_d;
  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_d;
  logic             beep_q;
  logic             beep_d;
  logic             unused_wr_bits;

  tone_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  tone_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .cnt_o  (cnt)
  );

  tone_tap_select #(
    .SEL_LSB (SEL_LSB),
    .SEL_W   (SEL_W),
    .CNT_W   (CNT_W),
    .TAP_W   (TAP_W)
  ) u_tap_select (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .sel_i   (sel_q),
    .ratio_i (ratio_i),
    .valid_o (tap_valid),
    .tap_o   (tap)
  );

  // register write decode; reserved bits are dropped
  always_comb begin
    en_d  = en_q;
    sel_d = sel_q;
    if (wr_en_i) begin
      if (wr_addr_i == ADDR_ENABLE) begin
        en_d = wr_data_i[0];
      end else begin
        sel_d = wr_data_i[SEL_LSB +: SEL_W];
      end
    end
  end

  always_comb begin
    beep_d = en_q & tap_valid & cnt[tap];
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      beep_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      sel_q  <= sel_d;
      beep_q <= beep_d;
    end
  end

  assign beep_o         = beep_q;
  assign unused_wr_bits = ^wr_data_i;

  // R5: disabled means silent on the following edge
  a_r5_off_is_low: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !en_q |=> !beep_o);

  // R7: empty field means silent on the following edge
  a_r7_no_tap_low: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !tap_valid |=> !beep_o);

  // R8: only bit 0 of an enable write is stored
  a_r8_enable_bit0: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (wr_en_i && (wr_addr_i == ADDR_ENABLE)) |=> (en_q == $past(wr_data_i[0])));

  // R6: select state changes only through a select write
  a_r6_sel_held: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !(wr_en_i && (wr_addr_i == ADDR_SELECT)) |=> $stable(sel_q));

  // R1: output low while the synchronized reset is held
  a_r1_reset_low: assert property (@(posedge clk_i)
    !rst_sync_n |-> !beep_o);

endmodule

// File: tb/tone_beep_gen_bench.sv
module tone_beep_gen_bench;

  localparam int unsigned SEL_LSB = 2;
  localparam int unsigned SEL_W   = 6;
  localparam int unsigned CNT_W   = SEL_LSB + SEL_W;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic        wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  ratio;
  logic        beep;

  int    compared   = 0;
  int    mismatched = 0;
  int    edges      = 0;
  bit    done       = 0;
  logic  m_en       = 1'b0;
  logic [SEL_W-1:0] m_sel = '0;
  logic  exp_beep   = 1'b0;
  string exp_req    = "R1";
  string focus      = "R1";

  always #2 clk = ~clk;

  tone_beep_gen #(
    .SEL_LSB (SEL_LSB),
    .SEL_W   (SEL_W)
  ) u_tone_beep_gen (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .ratio_i   (ratio),
    .beep_o    (beep)
  );

  // expected output from the requirements (R3..R7)
  function automatic logic model_beep(input logic en, input logic [SEL_W-1:0] sel,
                                      input logic [1:0] r, input int unsigned cnt,
                                      output string req);
    int idx = -1;
    int sh;
    int tap;
    for (int i = 0; i < int'(SEL_W); i++) begin
      if (sel[i] && idx < 0) idx = i;
    end
    if (!en) begin
      req = "R5";
      return 1'b0;
    end
    if (idx < 0) begin
      req = "R7";
      return 1'b0;
    end
    sh  = (r == 2'b01) ? 1 : (r == 2'b10) ? 5 : 0;
    tap = int'(SEL_LSB) + idx - sh;
    if (tap < 0) tap = 0;
    req = (sh == 0) ? "R3" : "R4";
    return logic'((cnt >> tap) & 1);
  endfunction

  // reference model advanced at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      edges    = 0;
      m_en     = 1'b0;
      m_sel    = '0;
      exp_beep = 1'b0;
      exp_req  = "R1";
    end else begin
      edges = edges + 1;
      if (edges < 3) begin
        exp_beep = 1'b0;
        exp_req  = "R1";
      end else begin
        int unsigned act;
        int unsigned c;
        act = edges - 2;
        c   = ((act - 1) / 2) % (1 << CNT_W);   // R2: half-rate count with wrap
        exp_beep = model_beep(m_en, m_sel, ratio, c, exp_req);
        if (wr_en) begin
          if (wr_addr == 1'b0) m_en = wr_data[0];
          else                 m_sel = wr_data[SEL_LSB +: SEL_W];
        end
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      compared = compared + 1;
      if (beep !== exp_beep) begin
        mismatched = mismatched + 1;
        $display("FAIL %s/%s at edge %0d: beep=%b expected=%b",
                 focus, exp_req, edges, beep, exp_beep);
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic write_reg(input logic addr, input logic [31:0] data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = addr;
    wr_data = data;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] field(input logic [SEL_W-1:0] f);
    return 32'(f) << SEL_LSB;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared   = compared + 1;
      mismatched = mismatched + 1;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd4242);
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = 1'b0;
    wr_data = '0;
    ratio   = 2'b00;

    // R1: reset state and release latency
    focus = "R1";
    run(6);
    rst_n = 1'b1;
    run(4);

    // R3: lowest tap at full speed
    focus = "R3";
    write_reg(1'b1, field(6'b000001));
    write_reg(1'b0, 32'h1);
    run(60);

    // R2: top tap, long enough to cover several counter wraps
    focus = "R2";
    write_reg(1'b1, field(6'b100000));
    run(1200);

    // R4: half speed, one thirty-second speed, clamp
    focus = "R4";
    ratio = 2'b01;
    run(300);
    ratio = 2'b10;
    run(120);
    write_reg(1'b1, field(6'b000001));
    run(60);
    write_reg(1'b1, field(6'b000100));
    run(60);

    // R3: spare ratio code behaves as full speed
    focus = "R3";
    ratio = 2'b11;
    write_reg(1'b1, field(6'b001000));
    run(120);
    ratio = 2'b00;

    // R6: several bits set, lowest decides
    focus = "R6";
    write_reg(1'b1, field(6'b101100));
    run(100);
    write_reg(1'b1, field(6'b111111));
    run(60);

    // R7: empty field is silent
    focus = "R7";
    write_reg(1'b1, 32'h0);
    run(80);

    // R8: reserved bits ignored
    focus = "R8";
    write_reg(1'b1, ~field(6'b111111));
    run(60);
    write_reg(1'b1, field(6'b001000) | 32'hFFFF_FF03);
    run(100);
    write_reg(1'b0, 32'hFFFF_FFFE);
    run(60);

    // R5: disable then re-enable, counter must have kept running
    focus = "R5";
    write_reg(1'b0, 32'h1);
    run(40);
    write_reg(1'b0, 32'h0);
    run(137);
    write_reg(1'b0, 32'h1);
    run(90);

    // R9: ratio changes mid-tone
    focus = "R9";
    for (int k = 0; k < 60; k++) begin
      ratio = 2'($urandom_range(0, 3));
      run(int'($urandom_range(1, 9)));
    end

    // random mix over all requirements
    focus = "RND";
    for (int k = 0; k < 200; k++) begin
      case ($urandom_range(0, 3))
        0: write_reg(1'b1, $urandom());
        1: write_reg(1'b1, field(6'(1 << $urandom_range(0, SEL_W - 1))));
        2: write_reg(1'b0, $urandom());
        default: ratio = 2'($urandom_range(0, 3));
      endcase
      run(int'($urandom_range(1, 200)));
    end

    done = 1;
    summary();
    $finish;
  end

endmodule